// File: doc/BRIEF.md
# Mode-Aware Dead-Time and Diode-Emulation Gate Sequencer

This block sits between the decoded PWM command and the two gate drivers of a synchronous buck half-bridge. It turns a high-side request and a low-side request into high-side and low-side gate enables that never overlap. It inserts a dead time at every hand-over, and the length of that dead time depends on the conduction mode. The hand-over from high side to low side uses a short fixed count. The hand-over from low side to high side uses a fixed minimum count when gate-voltage feedback is not in use. When feedback is in use, it waits for the low-side gate-discharged flag and then adds a further count. When the stage is carrying negative inductor current, it uses a long fixed count instead.

When diode emulation is selected (mode pin low), a zero-cross comparator watches the switch node while the low side conducts. A reported current reversal shuts the low-side gate. The low side then stays off until the next high-side request. The block also enables that comparator only while the low side is on, and it drops the low-side drive to its weak leg while negative current is flagged. All delays are counted in clock cycles. The analog sensing lies outside the block.

Top module: `gdt_gate_seq`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle. Once on, the high-side gate stays on for as long as `hs_req_i` stays 1.
- R2: After the high-side gate turns off, or when leaving idle, `ls_gate_o` rises exactly `DT_HL` cycles later if `ls_req_i` is still 1. The state of the switch node does not change this count.
- R3: With `adaptive_i`=0 and no negative current latched, `hs_gate_o` rises exactly `DT_MIN` cycles after the low-side gate turns off.
- R4: With `adaptive_i`=1, `hs_gate_o` rises only after `gl_low_i` has been sampled 1 during the dead time, followed by `DT_ADAPT` further cycles. The total is never less than `DT_MIN`. Any start of the high side from idle also goes through this dead time.
- R5: `ls_strong_o` is the inverse of `neg_cur_i` registered one cycle, so it is 0 (weak leg only) while negative current is flagged. It is 1 out of reset.
- R6: If negative current was registered when the low-to-high dead time began, that dead time lasts exactly `DT_CCM2` cycles. In this case `adaptive_i` and `gl_low_i` have no effect.
- R7: `zc_en_o` is 1 only from the second cycle of a low-side on-period. It falls in the same cycle the low-side gate falls.
- R8: With `zcd_mode_n_i`=0, a `zc_trip_i`=1 sampled while `zc_en_o`=1 turns the low-side gate off at that clock edge. A trip sampled while `zc_en_o`=0 is ignored.
- R9: After a zero-cross cutoff the low-side gate stays off whatever `ls_req_i` and `zc_trip_i` do. Only `hs_req_i`=1 ends the cutoff, and it then passes through the R3/R4 dead time.
- R10: With `zcd_mode_n_i`=1 (forced continuous mode), `zc_trip_i` has no effect on the low-side gate.
- R11: With both requests 0, both gates turn off at the next edge and remain off.
- R12: If `hs_req_i` falls while `ls_req_i`=1 during the low-to-high dead time, the low-side gate turns back on at the next edge and the high side never pulses.
- R13: While `rst_ni` is 0, both gates and `zc_en_o` are 0 and `ls_strong_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_req_i | input | 1 | High-side conduction request |
| ls_req_i | input | 1 | Low-side conduction request |
| zcd_mode_n_i | input | 1 | 0 selects diode emulation, 1 selects forced continuous mode |
| zc_trip_i | input | 1 | Zero-cross comparator reports reversed current |
| gl_low_i | input | 1 | Low-side gate voltage below turn-off threshold |
| neg_cur_i | input | 1 | Negative inductor current detected |
| adaptive_i | input | 1 | Use gate-feedback dead time for low-to-high hand-over |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| ls_strong_o | output | 1 | 1 enables both low-side drive legs, 0 only the weak leg |
| zc_en_o | output | 1 | Zero-cross comparator enable |

## Verification
The hardest case to reach from the ports is a zero-cross trip that comes at the wrong moment. A trip in the first cycle of a low-side on-period has to be ignored, and a trip after the cutoff must not bring the low side back. The stimulus holds `zc_trip_i` high from the first low-side cycle, then again during the cutoff while `ls_req_i` stays high. It also shows that only a high-side request releases the cutoff. The long negative-current dead time is driven with `adaptive_i` and `gl_low_i` both high, which shows that the feedback path cannot shorten it. A withdrawn high-side request in the middle of a dead time checks the return to the low side.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
  typedef enum logic [2:0] {
    S_OFF = 3'd0,
    S_HS  = 3'd1,
    S_HL  = 3'd2,
    S_LS  = 3'd3,
    S_LH  = 3'd4,
    S_CUT = 3'd5
  } gdt_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/gdt_sat_cnt.sv
module gdt_sat_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gdt_drive_mode.sv
module gdt_drive_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic neg_cur_i,
  output logic neg_q_o,
  output logic ls_strong_o
);
  logic neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= neg_cur_i;
  end

  assign neg_q_o     = neg_q;
  assign ls_strong_o = ~neg_q;

  a_r5_weak_follows_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(neg_cur_i) |=> !ls_strong_o);
endmodule

// File: rtl/gdt_zc_qual.sv
module gdt_zc_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ls_now_i,
  input  logic ls_next_i,
  input  logic zcd_mode_n_i,
  input  logic zc_trip_i,
  output logic zc_en_o,
  output logic cut_o
);
  logic zc_en_q;

  // comparator armed only once the low side has been on a full cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zc_en_q <= 1'b0;
    else         zc_en_q <= ls_now_i & ls_next_i;
  end

  assign zc_en_o = zc_en_q;
  assign cut_o   = zc_en_q & ~zcd_mode_n_i & zc_trip_i;

  a_r7_zc_needs_ls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_en_o |-> (ls_now_i && $past(ls_now_i)));
endmodule

// File: rtl/gdt_gate_seq.sv
module gdt_gate_seq
  import gdt_pkg::*;
#(
  parameter int unsigned DT_HL    = 2,
  parameter int unsigned DT_MIN   = 2,
  parameter int unsigned DT_ADAPT = 2,
  parameter int unsigned DT_CCM2  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_req_i,
  input  logic ls_req_i,
  input  logic zcd_mode_n_i,
  input  logic zc_trip_i,
  input  logic gl_low_i,
  input  logic neg_cur_i,
  input  logic adaptive_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic ls_strong_o,
  output logic zc_en_o
);
  localparam int unsigned DT_MAX = max3(DT_HL, DT_MIN, DT_CCM2);
  localparam int unsigned CW     = $clog2(DT_MAX + 1);
  localparam int unsigned ACW    = $clog2(DT_ADAPT + 1);
  localparam logic [CW-1:0]  HL_LAST   = CW'(DT_HL - 1);
  localparam logic [CW-1:0]  MIN_LAST  = CW'(DT_MIN - 1);
  localparam logic [CW-1:0]  CCM2_LAST = CW'(DT_CCM2 - 1);
  localparam logic [ACW-1:0] AD_LAST   = ACW'(DT_ADAPT - 1);

  gdt_state_e state_q, state_d;
  logic [CW-1:0]  cnt;
  logic [ACW-1:0] acnt;
  logic gl_seen_q, gl_seen_d;
  logic lh_long_q;
  logic neg_q, cut;
  logic hl_done, lh_fixed_ok, lh_adapt_ok;

  gdt_sat_cnt #(.W(CW)) u_dt_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .cnt_o (cnt)
  );

  gdt_sat_cnt #(.W(ACW)) u_adapt_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!((state_q == S_LH) && gl_seen_q)),
    .cnt_o (acnt)
  );

  gdt_drive_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .neg_cur_i  (neg_cur_i),
    .neg_q_o    (neg_q),
    .ls_strong_o(ls_strong_o)
  );

  gdt_zc_qual u_zc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ls_now_i    (state_q == S_LS),
    .ls_next_i   (state_d == S_LS),
    .zcd_mode_n_i(zcd_mode_n_i),
    .zc_trip_i   (zc_trip_i),
    .zc_en_o     (zc_en_o),
    .cut_o       (cut)
  );

  assign hl_done     = cnt >= HL_LAST;
  assign lh_fixed_ok = lh_long_q ? (cnt >= CCM2_LAST) : (cnt >= MIN_LAST);
  assign lh_adapt_ok = lh_long_q || !adaptive_i || (gl_seen_q && (acnt >= AD_LAST));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF: begin
        if (hs_req_i)      state_d = S_LH;
        else if (ls_req_i) state_d = S_HL;
      end
      S_HS: if (!hs_req_i) state_d = S_HL;
      S_HL: begin
        if (hl_done) begin
          if (ls_req_i)      state_d = S_LS;
          else if (hs_req_i) state_d = S_HS;
          else               state_d = S_OFF;
        end
      end
      S_LS: begin
        if (hs_req_i)       state_d = S_LH;
        else if (!ls_req_i) state_d = S_OFF;
        else if (cut)       state_d = S_CUT;
      end
      S_LH: begin
        if (!hs_req_i)                        state_d = ls_req_i ? S_LS : S_OFF;
        else if (lh_fixed_ok && lh_adapt_ok)  state_d = S_HS;
      end
      S_CUT: if (hs_req_i) state_d = S_LH;
      default: state_d = S_OFF;
    endcase
  end

  assign gl_seen_d = (state_q == S_LH) && (state_d == S_LH) && (gl_seen_q || gl_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_OFF;
      gl_seen_q <= 1'b0;
      lh_long_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      gl_seen_q <= gl_seen_d;
      if (state_d == S_LH && state_q != S_LH) lh_long_q <= neg_q;
    end
  end

  assign hs_gate_o = (state_q == S_HS);
  assign ls_gate_o = (state_q == S_LS);

  // dead-time observers for the assertions below
  localparam logic [CW-1:0] OBS_MAX = '1;
  logic [CW-1:0] hs_low_cnt, ls_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_low_cnt <= OBS_MAX;
      ls_low_cnt <= OBS_MAX;
    end else begin
      hs_low_cnt <= hs_gate_o ? '0 : ((hs_low_cnt == OBS_MAX) ? OBS_MAX : hs_low_cnt + 1'b1);
      ls_low_cnt <= ls_gate_o ? '0 : ((ls_low_cnt == OBS_MAX) ? OBS_MAX : ls_low_cnt + 1'b1);
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));

  a_r2_hl_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_o) |-> (hs_low_cnt >= CW'(DT_HL)));

  a_r3_lh_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_gate_o) |-> (ls_low_cnt >= CW'(DT_MIN)));

  a_r6_ccm2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_gate_o) && lh_long_q) |-> (ls_low_cnt >= CW'(DT_CCM2)));

  a_r9_cut_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CUT && !hs_req_i) |=> !ls_gate_o);
endmodule

// File: tb/gdt_gate_seq_tb.sv
module gdt_gate_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_req = 0, ls_req = 0, zcd_n = 1, zc_trip = 0, gl_low = 0, neg_cur = 0, adapt = 0;
  logic hs_gate, ls_gate, ls_strong, zc_en;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gdt_gate_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hs_req_i(hs_req), .ls_req_i(ls_req),
    .zcd_mode_n_i(zcd_n), .zc_trip_i(zc_trip), .gl_low_i(gl_low),
    .neg_cur_i(neg_cur), .adaptive_i(adapt),
    .hs_gate_o(hs_gate), .ls_gate_o(ls_gate), .ls_strong_o(ls_strong), .zc_en_o(zc_en)
  );

  // {req, hs ls zn trip gl neg ad, exp hs ls strong zc}
  localparam logic [14:0] VEC [64] = '{
    {4'd4, 7'b1010000, 4'b0010}, {4'd4, 7'b1010000, 4'b0010}, {4'd4, 7'b1010000, 4'b1010},
    {4'd1, 7'b1010000, 4'b1010}, {4'd2, 7'b0110000, 4'b0010}, {4'd2, 7'b0110000, 4'b0010},
    {4'd2, 7'b0110000, 4'b0110}, {4'd7, 7'b0110000, 4'b0111}, {4'd7, 7'b0110000, 4'b0111},
    {4'd3, 7'b1010000, 4'b0010}, {4'd3, 7'b1010000, 4'b0010}, {4'd3, 7'b1010000, 4'b1010},
    {4'd2, 7'b0110000, 4'b0010}, {4'd2, 7'b0110000, 4'b0010}, {4'd2, 7'b0110000, 4'b0110},
    {4'd7, 7'b0110000, 4'b0111}, {4'd4, 7'b1010001, 4'b0010}, {4'd4, 7'b1010001, 4'b0010},
    {4'd4, 7'b1010001, 4'b0010}, {4'd4, 7'b1010101, 4'b0010}, {4'd4, 7'b1010101, 4'b0010},
    {4'd4, 7'b1010101, 4'b1010}, {4'd2, 7'b0110000, 4'b0010}, {4'd2, 7'b0110000, 4'b0010},
    {4'd2, 7'b0110000, 4'b0110}, {4'd7, 7'b0110000, 4'b0111}, {4'd4, 7'b1010101, 4'b0010},
    {4'd4, 7'b1010101, 4'b0010}, {4'd4, 7'b1010101, 4'b0010}, {4'd4, 7'b1010101, 4'b1010},
    {4'd5, 7'b0110010, 4'b0000}, {4'd5, 7'b0110010, 4'b0000}, {4'd5, 7'b0110010, 4'b0100},
    {4'd5, 7'b0110010, 4'b0101}, {4'd6, 7'b1010111, 4'b0000}, {4'd6, 7'b1010111, 4'b0000},
    {4'd6, 7'b1010111, 4'b0000}, {4'd6, 7'b1010111, 4'b0000}, {4'd6, 7'b1010111, 4'b0000},
    {4'd6, 7'b1010111, 4'b0000}, {4'd6, 7'b1010111, 4'b1000}, {4'd5, 7'b1010000, 4'b1010},
    {4'd8, 7'b0100000, 4'b0010}, {4'd8, 7'b0100000, 4'b0010}, {4'd8, 7'b0100000, 4'b0110},
    {4'd7, 7'b0101000, 4'b0111}, {4'd8, 7'b0101000, 4'b0010}, {4'd9, 7'b0100000, 4'b0010},
    {4'd9, 7'b0101000, 4'b0010}, {4'd9, 7'b1000000, 4'b0010}, {4'd9, 7'b1000000, 4'b0010},
    {4'd9, 7'b1000000, 4'b1010}, {4'd10, 7'b0111000, 4'b0010}, {4'd10, 7'b0111000, 4'b0010},
    {4'd10, 7'b0111000, 4'b0110}, {4'd10, 7'b0111000, 4'b0111}, {4'd10, 7'b0111000, 4'b0111},
    {4'd11, 7'b0010000, 4'b0010}, {4'd11, 7'b0010000, 4'b0010}, {4'd11, 7'b0110000, 4'b0010},
    {4'd11, 7'b0110000, 4'b0010}, {4'd11, 7'b0110000, 4'b0110}, {4'd12, 7'b1010000, 4'b0010},
    {4'd12, 7'b0110000, 4'b0110}
  };

  function automatic string rname(logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";   4'd4: return "R4";
      4'd5: return "R5";   4'd6: return "R6";   4'd7: return "R7";   4'd8: return "R8";
      4'd9: return "R9";   4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string rq, input logic [3:0] exp, input int idx);
    logic [3:0] act;
    act = {hs_gate, ls_gate, ls_strong, zc_en};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: {hs,ls,strong,zc} actual %b expected %b", rq, idx, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R13", 4'b0010, -1);       // in reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 check("R13", 4'b0010, -2);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      {hs_req, ls_req, zcd_n, zc_trip, gl_low, neg_cur, adapt} = VEC[i][10:4];
      @(posedge clk); #2;
      check(rname(VEC[i][14:11]), VEC[i][3:0], i);
    end
    // R13: asynchronous reset in the middle of a high-side pulse, with weak drive selected
    @(negedge clk);
    {hs_req, ls_req, zcd_n, zc_trip, gl_low, neg_cur, adapt} = 7'b1010010;
    repeat (4) @(posedge clk);
    #2 check("R1", 4'b1000, 100);
    #1 rst_n = 1'b0;
    #1 check("R13", 4'b0010, 101);
    @(posedge clk); #2 check("R13", 4'b0010, 102);
    @(negedge clk) rst_n = 1'b1;
    // R4: start from idle after reset still honours the minimum dead time
    @(posedge clk); #2 check("R4", 4'b0000, 103);
    @(posedge clk); #2 check("R4", 4'b0000, 104);
    @(posedge clk); #2 check("R4", 4'b1000, 105);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule